// File: doc/BRIEF.md
# Serial Idle-Line Detector

This block watches the sampled receive line of a serial receiver, one sample per bit time, and raises an idle flag once the line has stayed high for as many consecutive bit times as the current frame holds. A frame-size input selects a frame of 10 or 11 bit times. The start bit of every frame is low, so a stream of back-to-back frames never produces an idle run.

A type-select input picks one of two detection types while the block runs. In short detection every high sample adds to the run, including the trailing data and stop bits of the frame just received. In long detection the run starts from zero after the receiver reports a finished frame, so the stop bit and the bits before it never count. Detection cannot be disabled. After it fires, the flag stays set, and it cannot fire again until the receiver reports another frame. Software clears the flag by reading status and then reading data, as it does for the other receiver flags.

Top module: `idle_line_det`

## Requirements
- R1: After reset the idle flag is 0, the run count is 0, detection is armed, and long detection treats the line as if a stop bit had just been received.
- R2: The flag goes to 1 on the clock after the bit tick that samples the Nth consecutive high bit, where N is 10 when `wide_frame` is 0 and 11 when `wide_frame` is 1. After N-1 high bits it stays 0.
- R3: A bit tick that samples `rx_bit` = 0 resets the run to zero. In long detection it also stops counting until the next `frame_done`.
- R4: With `long_type` = 1, `frame_done` clears the run. The stop-bit sample that comes with it does not count, and high bits count only from the next tick on.
- R5: With `long_type` = 0, `frame_done` leaves the run unchanged, so the stop bit and the data bits before it count toward N.
- R6: After the flag has been set, a new detection stays blocked until a `frame_done` has been seen. However long the line stays high, the flag is set only once.
- R7: A `data_rd` pulse clears the flag only if an earlier `stat_rd` pulse saw the flag at 1. A `data_rd` pulse with no such earlier `stat_rd` has no effect on the flag.
- R8: If a detection and a clearing `data_rd` fall in the same cycle, the flag ends up at 1.
- R9: Cycles without `bit_tick` change neither the run nor the flag, whatever `rx_bit` does in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking a valid sample of `rx_bit` |
| rx_bit | input | 1 | Sampled receive line level |
| frame_done | input | 1 | Receiver pulse: stop bit of a frame has been taken |
| wide_frame | input | 1 | Frame length select: 0 = 10 bit times, 1 = 11 |
| long_type | input | 1 | Detection type: 0 = short, 1 = long |
| stat_rd | input | 1 | Status read strobe, arms the clear |
| data_rd | input | 1 | Data read strobe, completes the clear |
| idle_flag | output | 1 | Idle line detected |

## Verification
A wrong run count shows up as the flag rising one or more ticks early or late against the frame length. Because every zero sample resets the count, this is visible within one idle period of 10 or 11 ticks. A stuck arming bit shows as a missing flag on the next idle line, or as a second rise without a frame in between. A wrong read-sequence bit shows on the first `data_rd` after the flag rises. The bench compares the flag in every cycle against a model built from the requirements, so any of these faults appears in the cycle where the port first diverges.

// File: rtl/idle_line_det.sv
module idle_line_det #(
  parameter int unsigned SHORT_BITS = 10,
  parameter int unsigned LONG_BITS  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic frame_done,
  input  logic wide_frame,
  input  logic long_type,
  input  logic stat_rd,
  input  logic data_rd,
  output logic idle_flag
);
  localparam int unsigned CW = $clog2(LONG_BITS + 1);
  localparam logic [CW-1:0] TOP = CW'(LONG_BITS);

  logic [CW-1:0] run_cnt, run_inc, tgt;
  logic after_stop, armed, seen, counting, restart, hit;

  assign tgt      = wide_frame ? CW'(LONG_BITS) : CW'(SHORT_BITS);
  assign restart  = long_type && frame_done;
  assign counting = rx_bit && (!long_type || after_stop);
  assign run_inc  = (run_cnt >= TOP) ? run_cnt : run_cnt + 1'b1;
  assign hit      = bit_tick && counting && !restart && armed && (run_inc >= tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      after_stop <= 1'b1;
      armed      <= 1'b1;
      seen       <= 1'b0;
      idle_flag  <= 1'b0;
    end else begin
      if (restart)
        run_cnt <= '0;
      else if (bit_tick)
        run_cnt <= !rx_bit ? '0 : (counting ? run_inc : run_cnt);

      if (frame_done)
        after_stop <= 1'b1;
      else if (bit_tick && !rx_bit)
        after_stop <= 1'b0;

      if (hit)
        armed <= 1'b0;
      else if (frame_done)
        armed <= 1'b1;

      if (hit)
        idle_flag <= 1'b1;
      else if (data_rd && seen)
        idle_flag <= 1'b0;

      if (data_rd && seen)
        seen <= 1'b0;
      else if (stat_rd)
        seen <= idle_flag;
    end
  end
endmodule

module idle_line_det_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          rx_bit,
  input logic          frame_done,
  input logic          long_type,
  input logic          data_rd,
  input logic          idle_flag,
  input logic [CW-1:0] run_cnt,
  input logic [CW-1:0] tgt
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !idle_flag);

  a_r9_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> ($past(bit_tick) && $past(rx_bit)));

  a_r2_rise_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> ({1'b0, $past(run_cnt)} + 1 >= {1'b0, $past(tgt)}));

  a_r7_fall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_flag) |-> $past(data_rd));

  a_r4_long_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (long_type && frame_done) |=> (run_cnt == '0));

  a_r3_zero_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_bit) |=> (run_cnt == '0));
endmodule

bind idle_line_det idle_line_det_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
  .frame_done(frame_done), .long_type(long_type), .data_rd(data_rd),
  .idle_flag(idle_flag), .run_cnt(run_cnt), .tgt(tgt)
);

// File: tb/sim_idle_line_det.sv
module sim_idle_line_det;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, rx_bit = 1, frame_done = 0, wide_frame = 0, long_type = 0;
  logic stat_rd = 0, data_rd = 0;
  logic idle_flag;

  int errors = 0, checks = 0;
  int m_cnt;
  bit m_go, m_arm, m_seen, m_flag;

  idle_line_det u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .frame_done(frame_done), .wide_frame(wide_frame), .long_type(long_type),
    .stat_rd(stat_rd), .data_rd(data_rd), .idle_flag(idle_flag)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic void model_reset();
    m_cnt = 0; m_go = 1; m_arm = 1; m_seen = 0; m_flag = 0;
  endfunction

  function automatic void model_step(bit t, bit r, bit fd, bit wf, bit lt, bit sr, bit dr);
    int need = wf ? 11 : 10;
    bit cnt_on = r && (!lt || m_go);
    int nxt = (m_cnt >= 11) ? m_cnt : m_cnt + 1;
    bit hit = t && cnt_on && !(lt && fd) && m_arm && (nxt >= need);
    bit clr = dr && m_seen;
    bit old_flag = m_flag;
    if (lt && fd) m_cnt = 0;
    else if (t) m_cnt = !r ? 0 : (cnt_on ? nxt : m_cnt);
    if (fd) m_go = 1; else if (t && !r) m_go = 0;
    if (hit) m_arm = 0; else if (fd) m_arm = 1;
    if (hit) m_flag = 1; else if (clr) m_flag = 0;
    if (clr) m_seen = 0; else if (sr) m_seen = old_flag;
  endfunction

  task automatic chk(bit exp, string req);
    checks++;
    if (idle_flag !== exp) begin
      errors++;
      $display("FAIL %s: idle_flag actual=%0b expected=%0b at %0t", req, idle_flag, exp, $time);
    end
  endtask

  task automatic step(bit t, bit r, bit fd, bit sr, bit dr, string req);
    @(negedge clk);
    bit_tick = t; rx_bit = r; frame_done = fd; stat_rd = sr; data_rd = dr;
    @(posedge clk);
    model_step(t, r, fd, wide_frame, long_type, sr, dr);
    #1;
    chk(m_flag, req);
  endtask

  task automatic ones(int n, string req);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0, req);
  endtask

  task automatic clear_flag(string req);
    step(0, 1, 0, 1, 0, req);
    step(0, 1, 0, 0, 1, req);
    chk(1'b0, req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 chk(1'b0, "R1");
    @(negedge clk) rst_n = 1'b1;

    ones(9, "R2");
    chk(1'b0, "R2 nine ones");
    ones(1, "R2");
    chk(1'b1, "R2 tenth one");

    step(0, 1, 0, 0, 1, "R7");
    chk(1'b1, "R7 data read alone ignored");
    clear_flag("R7");

    ones(15, "R6");
    chk(1'b0, "R6 no second set");

    step(1, 0, 0, 0, 0, "R5");
    ones(5, "R5");
    step(1, 1, 1, 0, 0, "R5");
    ones(3, "R5");
    chk(1'b0, "R5 nine counted");
    ones(1, "R5");
    chk(1'b1, "R5 stop bit counted");
    clear_flag("R5");

    long_type = 1'b1; wide_frame = 1'b1;
    step(1, 0, 0, 0, 0, "R4");
    ones(5, "R4");
    step(1, 1, 1, 0, 0, "R4");
    ones(10, "R4");
    chk(1'b0, "R4 ten after stop");
    ones(1, "R4");
    chk(1'b1, "R4 eleventh after stop");
    clear_flag("R4");

    step(1, 0, 0, 0, 0, "R3");
    step(1, 1, 1, 0, 0, "R3");
    ones(6, "R3");
    step(1, 0, 0, 0, 0, "R3");
    ones(20, "R3");
    chk(1'b0, "R3 zero halts long count");
    step(1, 1, 1, 0, 0, "R3");
    ones(11, "R3");
    chk(1'b1, "R3 count after new frame");
    clear_flag("R3");

    step(1, 0, 0, 0, 0, "R9");
    step(1, 1, 1, 0, 0, "R9");
    ones(5, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R9");
    ones(5, "R9");
    chk(1'b0, "R9 ten ticks");
    ones(1, "R9");
    chk(1'b1, "R9 non-tick zeros ignored");

    step(0, 1, 0, 1, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(1, 1, 1, 0, 0, "R8");
    ones(10, "R8");
    step(1, 1, 0, 0, 1, "R8");
    chk(1'b1, "R8 set beats clear");
    clear_flag("R8");

    for (int blk = 0; blk < 8; blk++) begin
      long_type  = $urandom_range(0, 1);
      wide_frame = $urandom_range(0, 1);
      for (int i = 0; i < 600; i++) begin
        bit t  = ($urandom_range(0, 3) != 0);
        bit r  = ($urandom_range(0, 9) != 0);
        bit fd = t && r && ($urandom_range(0, 15) == 0);
        bit sr = ($urandom_range(0, 7) == 0);
        bit dr = ($urandom_range(0, 7) == 0);
        step(t, r, fd, sr, dr, "R2-R9 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule